// File: doc/BRIEF.md
# Floating-Point Subtraction Special-Case Resolver

This unit sits in front of an extended-precision subtract datapath. It takes a minuend (`destOp`) and a subtrahend (`srcOp`) as 80-bit words. It sorts each one into one of four classes: NaN, infinity, zero or ordinary finite. For any pair that contains a NaN, an infinity or a zero, it builds the final difference itself and raises an invalid-operation flag where the arithmetic has no defined answer. When both operands are ordinary nonzero finite values, it raises `needsDp` instead, and the downstream mantissa datapath does the real work.

The interesting part is the signs. Infinities keep the sign of the operand that produced them, and a subtracted infinity has its sign flipped. Zero minus zero takes its sign from the signs of the two operands and, when they match, from the rounding mode. A zero subtrahend that came from an integer source always counts as positive zero. All outputs come from registers and appear one cycle after the input strobe.

Top module: `fsub_special`

## Requirements
- R1: An operand word has the sign in bit 79, a 15-bit biased exponent in bits 78:64 and a 64-bit significand in bits 63:0. An operand is classed as:
  - infinity when the exponent is 0x7FFF and bits 62:0 are zero;
  - NaN when the exponent is 0x7FFF and bits 62:0 are nonzero;
  - zero when both the exponent and the significand are zero;
  - finite otherwise.
- R2: If any operand is a NaN, the result is a NaN with the quiet bit (bit 62) set. With exactly one NaN, the result is that NaN, quieted. With two NaNs, the result is the one whose significand is larger as an unsigned number, quieted. A tie returns the minuend.
- R3: A NaN whose quiet bit is 0 is signalling. `invalid` is 1 exactly when at least one operand is a signalling NaN. A quiet NaN alone leaves `invalid` at 0.
- R4: When both operands are infinities of the same sign, `invalid` is 1 and the result is the default NaN `80'hFFFF_C000_0000_0000_0000`.
- R5: When both operands are infinities of opposite signs, the result is the minuend unchanged and `invalid` is 0.
- R6: When only the minuend is infinite, the result is the minuend. When only the subtrahend is infinite, the result is the subtrahend with its sign bit inverted. In neither case does the NaN class of the other operand apply, because a NaN takes precedence over both.
- R7: Rounding mode is encoded as 00 nearest, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. Zero minus a zero of the same sign gives -0 (`80'h8000_0000_0000_0000_0000`) in mode 01 and +0 (all bits zero) in every other mode.
- R8: Zero minus a zero of the opposite sign gives a zero carrying the minuend's sign, in every rounding mode.
- R9: When `isIntSrc` is 1 and the subtrahend is zero, the subtrahend's sign bit is ignored and it is treated as +0 in R7 and R8.
- R10: When the minuend is zero and the subtrahend is finite and nonzero, the result is the subtrahend with its sign inverted. When the subtrahend is zero and the minuend is finite and nonzero, the result is the minuend.
- R11: `needsDp` is 1 exactly when both operands are finite and nonzero. In that case `result` is all zeros and `invalid` is 0.
- R12: Reset clears all outputs to 0. An input accepted with `inValid` high drives `outValid`, `result`, `invalid` and `needsDp` at the next rising clock edge. With `inValid` low, `outValid` goes to 0 and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and mode are presented this cycle |
| destOp | input | 80 | Minuend operand |
| srcOp | input | 80 | Subtrahend operand |
| roundMode | input | 2 | Rounding mode, encoding in R7 |
| isIntSrc | input | 1 | Subtrahend came from an integer source |
| outValid | output | 1 | Registered outputs below are new this cycle |
| result | output | 80 | Special-case difference, zero when `needsDp` is set |
| invalid | output | 1 | Invalid-operation flag |
| needsDp | output | 1 | Pair must go to the finite subtract datapath |

## Verification
The hardest results to reach are the ones where several rules could apply at once. Examples are a signalling NaN paired with a quiet NaN whose significand is larger, two NaNs with equal significands, and a negative integer-sourced zero whose sign flip would change the zero-minus-zero outcome. The vector table builds each of these from hand-chosen bit patterns. Each pattern is picked so that a wrong priority or a wrong sign rule yields a different word. Directed steps around the table then check the reset values, check that nothing changes before the clock edge, and check that outputs hold when the strobe is low.

// File: rtl/fsub_special_pkg.sv
`timescale 1ns/1ps
package fsub_special_pkg;

  typedef enum logic [1:0] {
    CLS_FIN  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opClass_t;

  typedef enum logic [2:0] {
    SEL_NONE     = 3'd0,
    SEL_DEST     = 3'd1,
    SEL_SRC_NEG  = 3'd2,
    SEL_NAN_DEST = 3'd3,
    SEL_NAN_SRC  = 3'd4,
    SEL_DEF_NAN  = 3'd5,
    SEL_ZERO     = 3'd6
  } resSel_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic    load;
    resSel_t sel;
    logic    zeroSign;
    logic    invalid;
    logic    needsDp;
  } ctrlStrobe_t;

  localparam logic [1:0] RM_DOWN = 2'b01;

endpackage

// File: rtl/fsub_classify.sv
`timescale 1ns/1ps
module fsub_classify
  import fsub_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] opWord,
  output opClass_t             opCls,
  output logic                 isSignaling
);
  localparam int WORD_W = 1 + EXP_W + SIG_W;

  logic [EXP_W-1:0] expField;
  logic [SIG_W-1:0] sigField;
  logic             expMax;
  logic             fracZero;

  assign expField = opWord[WORD_W-2 -: EXP_W];
  assign sigField = opWord[SIG_W-1:0];
  assign expMax   = &expField;
  assign fracZero = (sigField[SIG_W-2:0] == '0);

  always_comb begin
    if (expMax) opCls = fracZero ? CLS_INF : CLS_NAN;
    else if (expField == '0 && sigField == '0) opCls = CLS_ZERO;
    else opCls = CLS_FIN;
  end

  assign isSignaling = (opCls == CLS_NAN) && !sigField[SIG_W-2];
endmodule

// File: rtl/fsub_ctrl.sv
`timescale 1ns/1ps
module fsub_ctrl
  import fsub_special_pkg::*;
#(
  parameter int SIG_W = 64
) (
  input  logic             inValid,
  input  opClass_t         dCls,
  input  opClass_t         sCls,
  input  logic             dSnan,
  input  logic             sSnan,
  input  logic             dSign,
  input  logic             sSign,
  input  logic [SIG_W-1:0] dSig,
  input  logic [SIG_W-1:0] sSig,
  input  logic             isIntSrc,
  input  logic [1:0]       roundMode,
  output ctrlStrobe_t      strb
);
  logic sSignEff;
  assign sSignEff = sSign & ~(isIntSrc & (sCls == CLS_ZERO));

  always_comb begin
    strb          = '0;
    strb.load     = inValid;
    strb.sel      = SEL_NONE;
    if (dCls == CLS_NAN || sCls == CLS_NAN) begin
      strb.invalid = dSnan | sSnan;
      if (dCls == CLS_NAN && sCls == CLS_NAN)
        strb.sel = (sSig > dSig) ? SEL_NAN_SRC : SEL_NAN_DEST;
      else if (dCls == CLS_NAN)
        strb.sel = SEL_NAN_DEST;
      else
        strb.sel = SEL_NAN_SRC;
    end else if (dCls == CLS_INF && sCls == CLS_INF) begin
      if (dSign == sSign) begin
        strb.sel     = SEL_DEF_NAN;
        strb.invalid = 1'b1;
      end else begin
        strb.sel = SEL_DEST;
      end
    end else if (dCls == CLS_INF) begin
      strb.sel = SEL_DEST;
    end else if (sCls == CLS_INF) begin
      strb.sel = SEL_SRC_NEG;
    end else if (dCls == CLS_ZERO && sCls == CLS_ZERO) begin
      strb.sel      = SEL_ZERO;
      strb.zeroSign = (dSign != sSignEff) ? dSign : (roundMode == RM_DOWN);
    end else if (dCls == CLS_ZERO) begin
      strb.sel = SEL_SRC_NEG;
    end else if (sCls == CLS_ZERO) begin
      strb.sel = SEL_DEST;
    end else begin
      strb.needsDp = 1'b1;
    end
  end
endmodule

// File: rtl/fsub_dpath.sv
`timescale 1ns/1ps
module fsub_dpath
  import fsub_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [EXP_W+SIG_W:0] destWord,
  input  logic [EXP_W+SIG_W:0] srcWord,
  output logic [EXP_W+SIG_W:0] resWord,
  output logic                 invFlag,
  output logic                 dpFlag,
  output logic                 resValid
);
  localparam int WORD_W = 1 + EXP_W + SIG_W;
  localparam logic [WORD_W-1:0] QUIET_MASK =
    {{(WORD_W-SIG_W+1){1'b0}}, 1'b1, {(SIG_W-2){1'b0}}};
  localparam logic [WORD_W-1:0] DEF_NAN =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic [WORD_W-1:0] nextWord;

  always_comb begin
    case (strb.sel)
      SEL_DEST:     nextWord = destWord;
      SEL_SRC_NEG:  nextWord = {~srcWord[WORD_W-1], srcWord[WORD_W-2:0]};
      SEL_NAN_DEST: nextWord = destWord | QUIET_MASK;
      SEL_NAN_SRC:  nextWord = srcWord | QUIET_MASK;
      SEL_DEF_NAN:  nextWord = DEF_NAN;
      SEL_ZERO:     nextWord = {strb.zeroSign, {(WORD_W-1){1'b0}}};
      default:      nextWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWord  <= '0;
      invFlag  <= 1'b0;
      dpFlag   <= 1'b0;
      resValid <= 1'b0;
    end else begin
      resValid <= strb.load;
      if (strb.load) begin
        resWord <= nextWord;
        invFlag <= strb.invalid;
        dpFlag  <= strb.needsDp;
      end
    end
  end
endmodule

// File: rtl/fsub_special.sv
`timescale 1ns/1ps
module fsub_special
  import fsub_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+SIG_W:0] destOp,
  input  logic [EXP_W+SIG_W:0] srcOp,
  input  logic [1:0]           roundMode,
  input  logic                 isIntSrc,
  output logic                 outValid,
  output logic [EXP_W+SIG_W:0] result,
  output logic                 invalid,
  output logic                 needsDp
);
  localparam int WORD_W = 1 + EXP_W + SIG_W;
  localparam int N_OPS  = 2;

  logic [WORD_W-1:0] opWords [N_OPS];
  opClass_t          opCls   [N_OPS];
  logic              opSnan  [N_OPS];
  ctrlStrobe_t       strb;

  assign opWords[0] = destOp;
  assign opWords[1] = srcOp;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fsub_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .opWord      (opWords[gi]),
      .opCls       (opCls[gi]),
      .isSignaling (opSnan[gi])
    );
  end

  fsub_ctrl #(.SIG_W(SIG_W)) u_ctrl (
    .inValid   (inValid),
    .dCls      (opCls[0]),
    .sCls      (opCls[1]),
    .dSnan     (opSnan[0]),
    .sSnan     (opSnan[1]),
    .dSign     (destOp[WORD_W-1]),
    .sSign     (srcOp[WORD_W-1]),
    .dSig      (destOp[SIG_W-1:0]),
    .sSig      (srcOp[SIG_W-1:0]),
    .isIntSrc  (isIntSrc),
    .roundMode (roundMode),
    .strb      (strb)
  );

  fsub_dpath #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .destWord (destOp),
    .srcWord  (srcOp),
    .resWord  (result),
    .invFlag  (invalid),
    .dpFlag   (needsDp),
    .resValid (outValid)
  );
endmodule

// File: rtl/fsub_special_chk.sv
`timescale 1ns/1ps
module fsub_special_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [EXP_W+SIG_W:0] destOp,
  input logic [EXP_W+SIG_W:0] srcOp,
  input logic [1:0]           roundMode,
  input logic                 isIntSrc,
  input logic                 outValid,
  input logic [EXP_W+SIG_W:0] result,
  input logic                 invalid,
  input logic                 needsDp
);
  localparam int WORD_W = 1 + EXP_W + SIG_W;

  logic dTop, sTop, dNan, sNan, dInf, sInf, dZero, sZero, sNeg;
  assign dTop  = &destOp[WORD_W-2 -: EXP_W];
  assign sTop  = &srcOp[WORD_W-2 -: EXP_W];
  assign dNan  = dTop && (destOp[SIG_W-2:0] != '0);
  assign sNan  = sTop && (srcOp[SIG_W-2:0] != '0);
  assign dInf  = dTop && (destOp[SIG_W-2:0] == '0);
  assign sInf  = sTop && (srcOp[SIG_W-2:0] == '0);
  assign dZero = (destOp[WORD_W-2:0] == '0);
  assign sZero = (srcOp[WORD_W-2:0] == '0);
  assign sNeg  = srcOp[WORD_W-1] && !isIntSrc;

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(invalid)));
  assert_datapath_route_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !dTop && !sTop && !dZero && !sZero)
      |=> (needsDp && !invalid && result == '0));
  assert_nan_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (dNan || sNan))
      |=> (&result[WORD_W-2 -: EXP_W] && result[SIG_W-2] && !needsDp));
  assert_inf_clash_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dInf && sInf && destOp[WORD_W-1] == srcOp[WORD_W-1])
      |=> invalid);
  assert_zero_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dZero && sZero && destOp[WORD_W-1] == sNeg && roundMode == 2'b01)
      |=> (result == {1'b1, {(WORD_W-1){1'b0}}}));
endmodule

bind fsub_special fsub_special_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .destOp    (destOp),
  .srcOp     (srcOp),
  .roundMode (roundMode),
  .isIntSrc  (isIntSrc),
  .outValid  (outValid),
  .result    (result),
  .invalid   (invalid),
  .needsDp   (needsDp)
);

// File: tb/fsub_special_bench.sv
`timescale 1ns/1ps
module fsub_special_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [79:0] destOp = '0;
  logic [79:0] srcOp = '0;
  logic [1:0]  roundMode = 2'b00;
  logic        isIntSrc = 1'b0;
  logic        outValid;
  logic [79:0] result;
  logic        invalid;
  logic        needsDp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fsub_special u_fsub_special (
    .clk(clk), .rstN(rstN), .inValid(inValid), .destOp(destOp), .srcOp(srcOp),
    .roundMode(roundMode), .isIntSrc(isIntSrc), .outValid(outValid),
    .result(result), .invalid(invalid), .needsDp(needsDp)
  );

  localparam logic [79:0] POS1  = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] NEG1  = 80'hBFFF_8000_0000_0000_0000;
  localparam logic [79:0] POS2  = 80'h4000_8000_0000_0000_0000;
  localparam logic [79:0] NEG2  = 80'hC000_8000_0000_0000_0000;
  localparam logic [79:0] PZ    = 80'h0000_0000_0000_0000_0000;
  localparam logic [79:0] NZ    = 80'h8000_0000_0000_0000_0000;
  localparam logic [79:0] PINF  = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] NINF  = 80'hFFFF_8000_0000_0000_0000;
  localparam logic [79:0] QNA   = 80'h7FFF_C000_0000_0000_1234;
  localparam logic [79:0] SNB   = 80'h7FFF_8000_0000_0000_0055;
  localparam logic [79:0] SNBQ  = 80'h7FFF_C000_0000_0000_0055;
  localparam logic [79:0] SNC   = 80'hFFFF_A000_0000_0000_0000;
  localparam logic [79:0] SNCQ  = 80'hFFFF_E000_0000_0000_0000;
  localparam logic [79:0] QND   = 80'h7FFF_C000_0000_0000_0001;
  localparam logic [79:0] QNE   = 80'hFFFF_C000_0000_0000_0001;
  localparam logic [79:0] DNAN  = 80'hFFFF_C000_0000_0000_0000;

  // {req(4), dest(80), src(80), mode(2), intSrc, expResult(80), expInvalid, expNeedsDp}
  localparam int NV = 22;
  localparam logic [248:0] VEC [NV] = '{
    {4'd11, POS1, POS2, 2'b00, 1'b0, PZ,   1'b0, 1'b1},  // R11
    {4'd7,  PZ,   PZ,   2'b00, 1'b0, PZ,   1'b0, 1'b0},  // R7
    {4'd7,  PZ,   PZ,   2'b01, 1'b0, NZ,   1'b0, 1'b0},  // R7
    {4'd7,  NZ,   NZ,   2'b10, 1'b0, PZ,   1'b0, 1'b0},  // R7
    {4'd7,  NZ,   NZ,   2'b01, 1'b0, NZ,   1'b0, 1'b0},  // R7
    {4'd8,  PZ,   NZ,   2'b01, 1'b0, PZ,   1'b0, 1'b0},  // R8
    {4'd8,  NZ,   PZ,   2'b00, 1'b0, NZ,   1'b0, 1'b0},  // R8
    {4'd9,  PZ,   NZ,   2'b01, 1'b1, NZ,   1'b0, 1'b0},  // R9
    {4'd9,  NZ,   NZ,   2'b00, 1'b1, NZ,   1'b0, 1'b0},  // R9
    {4'd4,  PINF, PINF, 2'b00, 1'b0, DNAN, 1'b1, 1'b0},  // R4
    {4'd5,  NINF, PINF, 2'b00, 1'b0, NINF, 1'b0, 1'b0},  // R5
    {4'd6,  POS1, NINF, 2'b00, 1'b0, PINF, 1'b0, 1'b0},  // R6
    {4'd6,  NINF, POS2, 2'b11, 1'b0, NINF, 1'b0, 1'b0},  // R6
    {4'd10, PZ,   POS2, 2'b00, 1'b0, NEG2, 1'b0, 1'b0},  // R10
    {4'd10, NEG1, NZ,   2'b01, 1'b0, NEG1, 1'b0, 1'b0},  // R10
    {4'd3,  QNA,  POS1, 2'b00, 1'b0, QNA,  1'b0, 1'b0},  // R3
    {4'd3,  POS1, SNB,  2'b00, 1'b0, SNBQ, 1'b1, 1'b0},  // R3
    {4'd2,  SNB,  QNA,  2'b00, 1'b0, QNA,  1'b1, 1'b0},  // R2
    {4'd2,  SNC,  SNB,  2'b00, 1'b0, SNCQ, 1'b1, 1'b0},  // R2
    {4'd1,  QNA,  PINF, 2'b00, 1'b0, QNA,  1'b0, 1'b0},  // R1 NaN vs infinity class
    {4'd11, POS1, NEG1, 2'b01, 1'b0, PZ,   1'b0, 1'b1},  // R11
    {4'd2,  QND,  QNE,  2'b00, 1'b0, QND,  1'b0, 1'b0}   // R2 tie
  };

  task automatic check80(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [248:0] v;
    logic [79:0] held;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check1("R12", "outValid", outValid, 1'b0);
    check80("R12", result, '0);
    check1("R12", "invalid", invalid, 1'b0);
    check1("R12", "needsDp", needsDp, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[248:245], i);
      @(negedge clk);
      destOp = v[244:165];
      srcOp = v[164:85];
      roundMode = v[84:83];
      isIntSrc = v[82];
      inValid = 1'b1;
      @(posedge clk);
      #1;
      check1(tag, "outValid", outValid, 1'b1);
      check80(tag, result, v[81:2]);
      check1(tag, "invalid", invalid, v[1]);
      check1(tag, "needsDp", needsDp, v[0]);
    end

    // R12: strobe low, outputs hold and outValid drops
    held = result;
    @(negedge clk);
    inValid = 1'b0;
    destOp = PINF;
    srcOp = PINF;
    @(posedge clk);
    #1;
    check1("R12 idle", "outValid", outValid, 1'b0);
    check80("R12 idle", result, held);
    check1("R12 idle", "invalid", invalid, 1'b0);

    // R12: no change before the edge, new value after one edge
    @(negedge clk);
    inValid = 1'b1;
    destOp = PZ;
    srcOp = POS1;
    roundMode = 2'b00;
    isIntSrc = 1'b0;
    #1;
    check1("R12 latency", "outValid", outValid, 1'b0);
    check80("R12 latency", result, held);
    @(posedge clk);
    #1;
    check80("R10 latency", result, NEG1);
    check1("R12 latency", "outValid", outValid, 1'b1);

    // R6 and R9 together: integer zero minuend side has no effect on infinity
    @(negedge clk);
    destOp = NZ;
    srcOp = NINF;
    isIntSrc = 1'b1;
    @(posedge clk);
    #1;
    check80("R6", result, PINF);
    @(negedge clk);
    inValid = 1'b0;
    finish_run();
  end
endmodule